// File: doc/BRIEF.md
# Read-Once Transmit-Only Serial Slave with Held Data Bank

This block lets a host controller on a two-wire serial bus (I2C) fetch five bytes that an upstream line decoder has captured. It only ever transmits: the master addresses it with a read byte, and the slave shifts out the held bytes one after another. The bytes sit in an output bank of their own. The decoder fills that bank by pulsing a load strobe whenever it has accepted a clean line. If the strobe arrives while a master is talking to the slave, the copy waits for the next bus START or STOP. Because of this, a read in progress never sees bytes from two different lines.

A flag records whether the held bytes are still unread. When a read transaction that delivered at least one byte comes to an end, the flag drops. From then on, every byte returns 0xFF until the decoder loads fresh data. Reset also leaves the slave returning 0xFF. Bytes requested past the fifth come back as 0xFF too. SCL and SDA are brought into the system clock domain and filtered before use. The SDA pin is modelled as an input plus a pull-low enable.

Top module: `vps_rd_slave`

## Requirements
- R1: The slave acknowledges a first byte of exactly 0x21 when `addr_sel` is 1, or exactly 0x23 when it is 0, by pulling SDA low in the ninth clock slot. Any other first byte, including one with the R/W bit 0, gets no acknowledge, and the slave keeps SDA released until the next START.
- R2: The data bytes go out in this order: `cap_bank[39:32]`, `[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`. Each byte is sent MSB first, and `sda_oe` = 1 drives a 0 bit.
- R3: Any byte the master requests after the fifth is 0xFF.
- R4: A `cap_load` pulse while the slave is not addressed copies `cap_bank` into the output bank and marks the data as unread.
- R5: A `cap_load` pulse while the slave is addressed leaves the output bank untouched. The copy is made at the next START or STOP, from the `cap_bank` value present then.
- R6: A transaction that sent at least one data byte marks the data as read when it ends with a STOP or a repeated START. Later reads return 0xFF for every byte.
- R7: A deferred copy that lands at the same bus event that ends a read leaves the new data marked unread.
- R8: After reset, every byte read is 0xFF until a load takes place.
- R9: While `rst` is high, the slave drives no SDA low, so its address is not acknowledged. Reset also empties the output bank to all ones.
- R10: After a master NACK, the slave releases SDA and drives nothing more until a START or STOP.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| addr_sel | input | 1 | Selects the answered address byte: 1 gives 0x21, 0 gives 0x23 |
| cap_bank | input | 40 | Capture bank from the line decoder, first byte in the top bits |
| cap_load | input | 1 | One-cycle strobe: the capture bank holds a good line |

## Verification
Two functions can fall in the same cycle: a deferred bank copy, and the read-done clear of the unread flag. Both are triggered by the STOP that closes a read. The bench provokes this by pulsing `cap_load` in the middle of a five-byte read. The bytes of that read must still come from the older bank. A read after the STOP must then return the new bytes rather than 0xFF, which shows the copy won over the clear. The reference model applies the clear first and the copy second, and SDA is compared against the model on every clock while the data line is meant to be steady.

// File: rtl/vps_rd_pkg.sv
package vps_rd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_SEND,
    ST_MACK,
    ST_WAIT
  } rd_state_t;
endpackage

// File: rtl/vps_bus_cond.sv
module vps_bus_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic [FILT_LEN-1:0]    scl_h, sda_h;
  logic                   scl_f, scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_h  <= '1;
      sda_h  <= '1;
      scl_f  <= 1'b1;
      sda_f  <= 1'b1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
      scl_h  <= {scl_h[FILT_LEN-2:0], scl_sy[SYNC_STAGES-1]};
      sda_h  <= {sda_h[FILT_LEN-2:0], sda_sy[SYNC_STAGES-1]};
      if (&scl_h)       scl_f <= 1'b1;
      else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h)       sda_f <= 1'b1;
      else if (~|sda_h) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_p  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_p   = scl_f & scl_d & ~sda_d & sda_f;
endmodule

// File: rtl/vps_out_bank.sv
module vps_out_bank #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cap_bank,
  input  logic         cap_load,
  input  logic         busy,
  input  logic         bus_evt,
  input  logic         consume,
  output logic [W-1:0] bank_q,
  output logic         new_flag,
  output logic         pending
);
  logic hold_now;
  assign hold_now = busy & ~bus_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q   <= '1;
      new_flag <= 1'b0;
      pending  <= 1'b0;
    end else begin
      // clear first so that a copy landing at the same event wins
      if (consume) new_flag <= 1'b0;
      if (pending && bus_evt) begin
        bank_q   <= cap_bank;
        new_flag <= 1'b1;
        pending  <= 1'b0;
      end
      if (cap_load) begin
        if (hold_now) begin
          pending <= 1'b1;
        end else begin
          bank_q   <= cap_bank;
          new_flag <= 1'b1;
          pending  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/vps_rd_engine.sv
module vps_rd_engine
  import vps_rd_pkg::*;
#(
  parameter int          NBYTES  = 5,
  parameter logic [7:0]  ADDR_HI = 8'h21,
  parameter logic [7:0]  ADDR_LO = 8'h23,
  localparam int         W       = BYTE_W * NBYTES,
  localparam int         IDX_W   = $clog2(NBYTES + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         scl_rise,
  input  logic         scl_fall,
  input  logic         sda_f,
  input  logic         start_p,
  input  logic         stop_p,
  input  logic         addr_sel,
  input  logic [W-1:0] bank_q,
  input  logic         new_flag,
  output logic         sda_oe,
  output logic         addressed,
  output logic         consume
);
  localparam int SLOTS = 2 ** IDX_W;

  rd_state_t        state;
  logic [3:0]       bit_cnt;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       addr_sh, tx;
  logic             m_ack, sent_any;
  logic [7:0]       slot [SLOTS];
  logic [7:0]       cur_byte, my_addr;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      if (g < NBYTES) begin : g_data
        assign slot[g] = bank_q[W-1-BYTE_W*g -: BYTE_W];
      end else begin : g_pad
        assign slot[g] = 8'hFF;
      end
    end
  endgenerate

  assign cur_byte = new_flag ? slot[byte_idx] : 8'hFF;
  assign my_addr  = addr_sel ? ADDR_HI : ADDR_LO;
  assign consume  = (start_p | stop_p) & sent_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      byte_idx  <= '0;
      addr_sh   <= '0;
      tx        <= '1;
      m_ack     <= 1'b0;
      sent_any  <= 1'b0;
      sda_oe    <= 1'b0;
      addressed <= 1'b0;
    end else if (start_p || stop_p) begin
      state     <= start_p ? ST_ADDR : ST_IDLE;
      bit_cnt   <= '0;
      byte_idx  <= '0;
      sent_any  <= 1'b0;
      sda_oe    <= 1'b0;
      addressed <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            addr_sh <= {addr_sh[6:0], sda_f};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            if (addr_sh == my_addr) begin
              state     <= ST_AACK;
              sda_oe    <= 1'b1;
              addressed <= 1'b1;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            tx      <= cur_byte;
            sda_oe  <= ~cur_byte[7];
            bit_cnt <= 4'd1;
            state   <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_oe   <= 1'b0;
              sent_any <= 1'b1;
              state    <= ST_MACK;
              if (byte_idx != IDX_W'(NBYTES)) byte_idx <= byte_idx + 1'b1;
            end else begin
              sda_oe  <= ~tx[6];
              tx      <= {tx[6:0], 1'b1};
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_f;
          end else if (scl_fall) begin
            if (m_ack) begin
              tx      <= cur_byte;
              sda_oe  <= ~cur_byte[7];
              bit_cnt <= 4'd1;
              state   <= ST_SEND;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vps_rd_slave.sv
module vps_rd_slave #(
  parameter int         NBYTES      = 5,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter logic [7:0] ADDR_HI     = 8'h21,
  parameter logic [7:0] ADDR_LO     = 8'h23,
  localparam int        DATA_W      = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              addr_sel,
  input  logic [DATA_W-1:0] cap_bank,
  input  logic              cap_load
);
  logic              sda_f, scl_rise, scl_fall, start_p, stop_p;
  logic              bus_evt, busy, consume, new_flag, pend;
  logic [DATA_W-1:0] bank_q;

  assign bus_evt = start_p | stop_p;

  vps_bus_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_f(sda_f), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  vps_out_bank #(.W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .cap_bank(cap_bank), .cap_load(cap_load),
    .busy(busy), .bus_evt(bus_evt), .consume(consume),
    .bank_q(bank_q), .new_flag(new_flag), .pending(pend)
  );

  vps_rd_engine #(.NBYTES(NBYTES), .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)) u_eng (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_f(sda_f), .start_p(start_p), .stop_p(stop_p), .addr_sel(addr_sel),
    .bank_q(bank_q), .new_flag(new_flag), .sda_oe(sda_oe),
    .addressed(busy), .consume(consume)
  );
endmodule

// File: rtl/vps_rd_slave_chk.sv
module vps_rd_slave_chk #(
  parameter int W = 40
) (
  input logic         clk,
  input logic         rst,
  input logic         scl_i,
  input logic         sda_oe,
  input logic         cap_load,
  input logic [W-1:0] cap_bank,
  input logic         busy,
  input logic         bus_evt,
  input logic         pending,
  input logic         new_flag,
  input logic [W-1:0] bank_q,
  input logic         consume
);
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!sda_oe && !busy && bank_q == '1));

  p_load_now_r4: assert property (@(posedge clk) disable iff (rst)
    (cap_load && !busy) |=> (new_flag && bank_q == $past(cap_bank)));

  p_defer_r5: assert property (@(posedge clk) disable iff (rst)
    (cap_load && busy && !bus_evt) |=> (pending && $stable(bank_q)));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (pending && bus_evt) |=> (new_flag && !pending && bank_q == $past(cap_bank)));

  p_consume_r6: assert property (@(posedge clk) disable iff (rst)
    (consume && !pending && !cap_load) |=> !new_flag);
endmodule

bind vps_rd_slave vps_rd_slave_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .cap_load(cap_load), .cap_bank(cap_bank), .busy(busy), .bus_evt(bus_evt),
  .pending(pend), .new_flag(new_flag), .bank_q(bank_q), .consume(consume)
);

// File: tb/tb_vps_rd_slave.sv
module tb_vps_rd_slave;
  localparam int HP = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, scl_m, sda_m, addr_sel, cap_load;
  logic [39:0] cap_bank;
  logic        sda_oe;
  logic        sda_line;
  assign sda_line = sda_m & ~sda_oe;

  vps_rd_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .cap_bank(cap_bank), .cap_load(cap_load)
  );

  int    n_chk = 0, n_fail = 0;
  bit    win = 0, exp_oe = 0, done = 0;
  string tag = "R9";

  // behavioural model
  logic [39:0] m_bank = '1;
  bit m_valid = 0, m_pend = 0, m_addr = 0, m_sent = 0;

  function automatic logic [7:0] exp_byte(int i);
    if (m_valid && i < 5) return m_bank[39-8*i -: 8];
    return 8'hFF;
  endfunction

  task automatic bus_event();
    if (m_sent) m_valid = 0;
    if (m_pend) begin m_bank = cap_bank; m_valid = 1; m_pend = 0; end
    m_sent = 0;
    m_addr = 0;
  endtask

  task automatic chk(bit ok, string t, int act, int ex);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", t, act, ex, $time);
    end
  endtask

  // per-clock comparison against the model while SDA should be steady
  logic prev_oe = 0;
  always @(posedge clk) begin
    #1;
    if (win) chk(sda_oe === exp_oe, tag, sda_oe, exp_oe);
    if (sda_oe !== prev_oe && scl_m) chk(0, "R11", sda_oe, prev_oe);
    prev_oe = sda_oe;
  end

  task automatic hp(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1;
    if (!scl_m) begin hp(HP); scl_m = 1; end
    hp(HP); sda_m = 0; hp(HP); scl_m = 0;
    bus_event();
  endtask

  task automatic do_stop();
    sda_m = 0; hp(HP); scl_m = 1; hp(HP); sda_m = 1; hp(HP);
    bus_event();
  endtask

  task automatic clk_bit(bit mb, bit e, string t);
    sda_m = mb; exp_oe = e; tag = t;
    hp(HP/2); win = 1; hp(HP/2);
    scl_m = 1; hp(HP);
    win = 0; scl_m = 0;
  endtask

  task automatic pulse_load(logic [39:0] v);
    cap_bank = v; cap_load = 1; hp(1); cap_load = 0;
    if (m_addr) m_pend = 1;
    else begin m_bank = v; m_valid = 1; end
  endtask

  task automatic read_txn(logic [7:0] a, int nb, bit exp_ack, string t,
                          bit end_stop = 1, int load_at = -1,
                          logic [39:0] load_val = '0);
    logic [7:0] eb;
    do_start();
    for (int i = 0; i < 8; i++) clk_bit(a[7-i], 0, "R1");
    clk_bit(1, exp_ack, exp_ack ? "R1" : (rst ? "R9" : "R1"));
    if (!exp_ack) begin
      clk_bit(1, 0, "R1");
      do_stop();
      return;
    end
    m_addr = 1;
    for (int b = 0; b < nb; b++) begin
      if (b == load_at) begin
        pulse_load(load_val);
        chk(1, "R5", 0, 0);
      end
      eb = exp_byte(b);
      for (int i = 0; i < 8; i++) clk_bit(1, ~eb[7-i], (b >= 5) ? "R3" : t);
      m_sent = 1;
      clk_bit((b == nb-1), 0, "R10");
    end
    clk_bit(1, 0, "R10");
    clk_bit(0, 0, "R10");
    if (end_stop) do_stop();
  endtask

  initial begin
    #(190000 * 4);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1; scl_m = 1; sda_m = 1; addr_sel = 1; cap_load = 0; cap_bank = '0;
    hp(10);
    chk(sda_oe === 1'b0, "R9", sda_oe, 0);
    // R9: no acknowledge while reset is held
    read_txn(8'h21, 1, 0, "R9");
    rst = 0; hp(10);
    // R8: nothing loaded yet
    read_txn(8'h21, 2, 1, "R8");
    // R2 / R4: direct load, full read
    pulse_load(40'h1122334455);
    read_txn(8'h21, 5, 1, "R2");
    // R6: read-once
    read_txn(8'h21, 2, 1, "R6");
    // R3: padding past the fifth byte
    pulse_load(40'hA55AC33C0F);
    read_txn(8'h21, 8, 1, "R4");
    // R1: address select low
    addr_sel = 0;
    pulse_load(40'h00FF80017E);
    read_txn(8'h21, 1, 0, "R1");
    read_txn(8'h20, 1, 0, "R1");
    read_txn(8'h23, 5, 1, "R2");
    addr_sel = 1;
    read_txn(8'h23, 1, 0, "R1");
    // R5 / R7: load during a read, released by the closing STOP
    pulse_load(40'h0102040810);
    read_txn(8'h21, 5, 1, "R5", 1, 2, 40'hF0E1D2C3B4);
    read_txn(8'h21, 5, 1, "R7");
    // R6 through a repeated START
    pulse_load(40'h6699AA5533);
    read_txn(8'h21, 1, 1, "R2", 0);
    read_txn(8'h21, 3, 1, "R6");
    // R8: reset drops held data
    pulse_load(40'h123456789A);
    rst = 1; hp(4); rst = 0; hp(4);
    m_bank = '1; m_valid = 0; m_pend = 0; m_addr = 0; m_sent = 0;
    read_txn(8'h21, 2, 1, "R8");
    hp(20);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule